// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the timing strobes for an asynchronous serial transmitter and receiver from the system clock. Software loads a 16-bit fixed-point divisor. The upper twelve bits hold the whole number of clocks per oversample. The low four bits hold a fractional remainder. A mode bit, loaded with the same write, chooses sixteen or eight oversamples per bit. Sixteen oversamples give a finer fraction and better tolerance to noise. Eight oversamples give a higher top rate.

Single-clock oversample strobes drive the receiver's sampling. A bit strobe marks every bit boundary for the shift logic. Fractional remainders cannot be expressed in whole clocks. They are spread across the oversample periods of each bit. A small accumulator adds one extra clock to a period whenever its sum carries, so the average period matches the programmed value exactly. Each write restarts every counter from the new value. A zero whole part silences both strobes.

Top module: `frac_baud_gen`

## Requirements
- R1: With `cfg_os8`=0 (sixteen oversamples per bit), the bit period is 16·M + F clock cycles. M is `cfg_div[15:4]` and F is `cfg_div[3:0]`. For example, 0x2D9 gives 729 cycles.
- R2: With `cfg_os8`=1 (eight oversamples per bit), the bit period is 8·M + F3 clock cycles, where F3 is `cfg_div[2:0]`. Bit 3 of `cfg_div` has no effect. Keeping a divisor meant for sixteen oversamples therefore roughly halves the bit period.
- R3: `os_tick` is a one-cycle strobe. Every oversample period lasts either M or M+1 clock cycles.
- R4: Within one bit, the number of oversample periods that last M+1 cycles equals the fraction: F in 16x mode and F3 in 8x mode. A zero fraction gives only M-cycle periods.
- R5: `bit_tick` is high only together with `os_tick`. It fires on every 16th oversample strobe (16x mode) or every 8th (8x mode), counted from the last write.
- R6: A write (`cfg_we` high at a rising edge) discards any partial period. The first `os_tick` follows exactly M cycles after that edge.
- R7: While the stored M is zero, `os_tick` and `bit_tick` stay low.
- R8: After reset, both strobes are low and the divisor holds RST_DIV. The default RST_DIV is 0, so no strobes occur until the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for divisor and mode |
| cfg_div | input | 16 | Fixed-point divisor: whole part [15:4], fraction [3:0] |
| cfg_os8 | input | 1 | Mode loaded with the divisor: 1 = eight oversamples per bit, 0 = sixteen |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle bit-boundary strobe, coincident with an `os_tick` |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, a 4-bit fraction, and a reset divisor of zero. With these values, a 729-cycle bit at 0x2D9 and its 8x counterparts fit within a few thousand cycles. This makes it practical to measure every oversample interval of two whole bits and count the lengthened ones. Small divisors such as M=1 with F=15 reach the case where periods shrink to one or two clocks. A mid-period rewrite and the zero-whole-part setting are exercised at the same widths.

// File: rtl/fbrg_pkg.sv
package fbrg_pkg;
  typedef enum logic {
    OS_X16 = 1'b0,
    OS_X8  = 1'b1
  } os_mode_e;
endpackage

// File: rtl/fbrg_cfg_reg.sv
module fbrg_cfg_reg
  import fbrg_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int RST_DIV = 0,
  localparam int MANT_W = DIV_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_os8,
  output logic [MANT_W-1:0] mant_eff,
  output logic [FRAC_W-1:0] inc_eff,
  output os_mode_e          mode_eff,
  output logic [MANT_W-1:0] mant_q,
  output logic              restart,
  output logic              active
);
  logic [DIV_W-1:0] div_q;
  os_mode_e         mode_q;
  logic             start_q;
  logic [DIV_W-1:0] div_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= DIV_W'(RST_DIV);
      mode_q  <= OS_X16;
      start_q <= 1'b1;
    end else begin
      start_q <= 1'b0;
      if (cfg_we) begin
        div_q  <= cfg_div;
        mode_q <= os_mode_e'(cfg_os8);
      end
    end
  end

  // a write is seen by the counters at the same edge that stores it
  always_comb begin
    div_eff  = cfg_we ? cfg_div : div_q;
    mode_eff = cfg_we ? os_mode_e'(cfg_os8) : mode_q;
    mant_eff = div_eff[DIV_W-1:FRAC_W];
    // fraction expressed in units of 1/2**FRAC_W; 8x mode drops the top bit
    if (mode_eff == OS_X8) inc_eff = {div_eff[FRAC_W-2:0], 1'b0};
    else                   inc_eff = div_eff[FRAC_W-1:0];
  end

  assign mant_q  = div_q[DIV_W-1:FRAC_W];
  assign restart = cfg_we | start_q;
  assign active  = (mant_eff != '0);
endmodule

// File: rtl/fbrg_frac_acc.sv
module fbrg_frac_acc
  import fbrg_pkg::*;
#(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              wrap,
  input  logic [FRAC_W-1:0] inc,
  input  os_mode_e          mode,
  output logic              extra
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, inc};
  assign extra = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (restart) acc_q <= inc;  // first period never carries
    else if (wrap)    acc_q <= sum[FRAC_W-1:0];
  end

  // R2: in 8x mode only even sixteenths are ever added
  p_acc_even_r2: assert property (@(posedge clk) disable iff (rst)
    (!restart && mode == OS_X8) |-> !acc_q[0]);
endmodule

// File: rtl/fbrg_period_cnt.sv
module fbrg_period_cnt #(
  parameter int MANT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              active,
  input  logic [MANT_W-1:0] mant,
  input  logic              extra,
  output logic              wrap,
  output logic              os_tick
);
  localparam logic [MANT_W-1:0] ONE = MANT_W'(1);
  logic [MANT_W-1:0] cnt_q;

  assign wrap = active && !restart && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      os_tick <= 1'b0;
    end else begin
      os_tick <= wrap;
      if (restart)     cnt_q <= active ? (mant - ONE) : '0;
      else if (wrap)   cnt_q <= mant - ONE + MANT_W'(extra);
      else if (active) cnt_q <= cnt_q - ONE;
    end
  end

  // R3: a period never exceeds M+1 cycles
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (!restart && active) |-> (cnt_q <= mant));
endmodule

// File: rtl/fbrg_bit_div.sv
module fbrg_bit_div
  import fbrg_pkg::*;
#(
  parameter int FRAC_W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     restart,
  input  logic     wrap,
  input  os_mode_e mode,
  output logic     bit_tick
);
  localparam logic [FRAC_W-1:0] LAST16 = FRAC_W'((2 ** FRAC_W) - 1);
  localparam logic [FRAC_W-1:0] LAST8  = FRAC_W'((2 ** (FRAC_W - 1)) - 1);

  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W-1:0] last;
  logic              at_last;

  assign last    = (mode == OS_X8) ? LAST8 : LAST16;
  assign at_last = (phase_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= wrap && at_last;
      if (restart)   phase_q <= '0;
      else if (wrap) phase_q <= at_last ? '0 : phase_q + FRAC_W'(1);
    end
  end

  // R5: oversample phase stays inside the selected ratio
  p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (phase_q <= last));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbrg_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int RST_DIV = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_os8,
  output logic             os_tick,
  output logic             bit_tick
);
  localparam int MANT_W = DIV_W - FRAC_W;

  logic [MANT_W-1:0] mant_eff;
  logic [MANT_W-1:0] mant_q;
  logic [FRAC_W-1:0] inc_eff;
  os_mode_e          mode_eff;
  logic              restart;
  logic              active;
  logic              extra;
  logic              wrap;

  fbrg_cfg_reg #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .RST_DIV(RST_DIV)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_os8(cfg_os8),
    .mant_eff(mant_eff), .inc_eff(inc_eff), .mode_eff(mode_eff), .mant_q(mant_q),
    .restart(restart), .active(active)
  );

  fbrg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .restart(restart), .wrap(wrap), .inc(inc_eff),
    .mode(mode_eff), .extra(extra)
  );

  fbrg_period_cnt #(.MANT_W(MANT_W)) u_cnt (
    .clk(clk), .rst(rst), .restart(restart), .active(active), .mant(mant_eff),
    .extra(extra), .wrap(wrap), .os_tick(os_tick)
  );

  fbrg_bit_div #(.FRAC_W(FRAC_W)) u_bit (
    .clk(clk), .rst(rst), .restart(restart), .wrap(wrap), .mode(mode_eff),
    .bit_tick(bit_tick)
  );

  // R5: a bit boundary is always also an oversample point
  p_bit_on_os_r5: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);

  // R7: zero whole part keeps both strobes quiet
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (mant_q == '0) |-> (!os_tick && !bit_tick));

  // R3: strobe lasts one cycle whenever a period is longer than one clock
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (rst)
    (os_tick && !restart && mant_q > MANT_W'(1)) |=> !os_tick);
endmodule

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_div = '0;
  logic        cfg_os8 = 1'b0;
  logic        os_tick;
  logic        bit_tick;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int os_pos[$];
  int bit_pos[$];
  int bit_alone;

  always #5 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_os8(cfg_os8),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ends at the negedge just after the capturing edge
  task automatic write_div(input logic [15:0] d, input logic os8);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = d; cfg_os8 = os8;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic observe(input int ncyc);
    os_pos.delete(); bit_pos.delete(); bit_alone = 0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (os_tick) os_pos.push_back(k);
      if (bit_tick) begin
        bit_pos.push_back(k);
        if (!os_tick) bit_alone++;
      end
    end
  endtask

  task automatic scen_rate(input string req, input logic [15:0] d, input logic os8,
                           input int m, input int f, input int ratio);
    int bitp, n_os, n_long, n_bad, iv;
    bitp = ratio * m + f;
    write_div(d, os8);
    observe(2 * bitp + 5);
    chk("R6", "first oversample strobe", os_pos.size() > 0 ? os_pos[0] : -1, m);
    chk(req, "first bit strobe", bit_pos.size() > 0 ? bit_pos[0] : -1, bitp);
    chk(req, "second bit strobe", bit_pos.size() > 1 ? bit_pos[1] : -1, 2 * bitp);
    chk("R5", "bit strobe without oversample", bit_alone, 0);
    n_os = 0; n_long = 0; n_bad = 0;
    foreach (os_pos[i]) begin
      iv = (i == 0) ? os_pos[0] : os_pos[i] - os_pos[i-1];
      if (iv != m && iv != m + 1) n_bad++;
      if (bit_pos.size() > 0 && os_pos[i] <= bit_pos[0]) begin
        n_os++;
        if (iv == m + 1) n_long++;
      end
    end
    chk("R5", "oversamples per bit", n_os, ratio);
    chk("R4", "lengthened periods per bit", n_long, f);
    chk("R3", "periods outside M..M+1", n_bad, 0);
  endtask

  task automatic scen_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "os_tick in reset", int'(os_tick), 0);
    chk("R8", "bit_tick in reset", int'(bit_tick), 0);
    rst = 1'b0;
    observe(100);
    chk("R8", "strobes after reset", os_pos.size() + bit_pos.size(), 0);
  endtask

  task automatic scen_zero_mant();
    write_div(16'h002D, 1'b0);
    observe(10);
    write_div(16'h000F, 1'b0);
    observe(300);
    chk("R7", "strobes with zero whole part", os_pos.size() + bit_pos.size(), 0);
  endtask

  task automatic scen_restart();
    write_div(16'h02D9, 1'b0);
    observe(20);
    scen_rate("R6", 16'h0031, 1'b0, 3, 1, 16);
  endtask

  initial begin
    scen_reset();
    scen_rate("R1", 16'h02D9, 1'b0, 45, 9, 16);
    scen_rate("R2", 16'h02D7, 1'b1, 45, 7, 8);
    scen_rate("R2", 16'h02DF, 1'b1, 45, 7, 8);
    scen_rate("R2", 16'h02D9, 1'b1, 45, 1, 8);
    scen_rate("R4", 16'h0050, 1'b0, 5, 0, 16);
    scen_rate("R1", 16'h001F, 1'b0, 1, 15, 16);
    scen_zero_mant();
    scen_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule